// File: doc/BRIEF.md
# Indexed Effective Address Generator

This unit forms the operand address for the indexed addressing forms of a 16-bit-address accumulator processor. A decoder presents a mode code, a base selector, the current X, Y, SP and PC values, the A and B accumulators (D is their concatenation, A high), and the offset bits taken from the instruction stream. The unit then returns the effective address. For the auto-modify forms it also returns the updated base value for the register file to write back.

Two forms are memory-indirect. In these forms the computed sum is the location of a 16-bit pointer, and the pointer itself is the effective address. The unit fetches the pointer one byte at a time over a valid/ready read port. The high byte sits at the lower address. A request is issued while `rd_valid` is high, and a byte is transferred in any cycle where `rd_valid` and `rd_ready` are both high, with `rd_data` holding that byte. Every result is announced by a one-cycle `done` pulse. The result outputs then hold their values until the next `done`.

Top module: `idx_ea_gen`

## Requirements
- R1: A `start` accepted while idle with a non-indirect mode gives `done` on the very next cycle, and `done` is a one-cycle pulse. `base_sel` picks the base: 0 X, 1 Y, 2 SP, 3 PC. Mode 0 gives base + sign-extended `ofs5` (range -16..+15), with `wb_en` low.
- R2: Mode 1 gives base + the 9-bit signed value {`ofs_sign`, `ext_lo`} (range -256..+255), with `wb_en` low.
- R3: Mode 2 gives base + {`ext_hi`, `ext_lo`}, truncated to 16 bits so that the sum wraps past 0xFFFF, with `wb_en` low.
- R4: Modes 4, 5 and 6 give base + zero-extended A, base + zero-extended B and base + D respectively, with `wb_en` low.
- R5: Modes 8 (pre-increment) and 9 (pre-decrement) change the base by `step`+1 (1..8), wrapping at 16 bits. The changed value is returned on both `ea` and `wb_val`, with `wb_en` high.
- R6: Modes 10 (post-increment) and 11 (post-decrement) return the unchanged base on `ea`. The base changed by `step`+1 is returned on `wb_val`, with `wb_en` high.
- R7: An auto-modify mode with PC as base, or any mode code from 12 to 15, gives `done` with `illegal` high, `wb_en` low and `ea` = 0. Every other result has `illegal` low.
- R8: Mode 3 reads the byte at P = base + {`ext_hi`, `ext_lo`} and then the byte at P+1, where the address wraps. The result is `ea` = {byte at P, byte at P+1}, with `wb_en` low. `done` comes on the cycle after the second transfer.
- R9: Mode 7 forms the pointer location as base + D and then fetches the pointer as in R8.
- R10: While a read is pending without `rd_ready`, `rd_valid` stays high and `rd_addr` does not change. A `start` that arrives during an indirect fetch is ignored.
- R11: During and right after reset, `done`, `rd_valid`, `wb_en` and `illegal` are low, and `ea` and `wb_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an address computation (taken only when idle) |
| mode | input | 4 | Indexed form code |
| base_sel | input | 2 | Base register: 0 X, 1 Y, 2 SP, 3 PC |
| step | input | 3 | Auto-modify amount minus one |
| ofs5 | input | 5 | Short signed offset |
| ofs_sign | input | 1 | Sign bit of the 9-bit offset |
| ext_hi | input | 8 | High offset byte |
| ext_lo | input | 8 | Low offset byte |
| reg_x | input | 16 | X register |
| reg_y | input | 16 | Y register |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter |
| acc_a | input | 8 | Accumulator A (high half of D) |
| acc_b | input | 8 | Accumulator B (low half of D) |
| rd_valid | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte address |
| rd_ready | input | 1 | Read accepted, data present |
| rd_data | input | 8 | Read byte |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| wb_en | output | 1 | Base write-back required |
| wb_val | output | 16 | Updated base value |
| illegal | output | 1 | Illegal mode/base combination |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 3-bit step field. At these sizes it can reach every mode code, all four bases and all eight step amounts in a single run. Each combination is driven with pseudo-random registers and offsets, and with forced values sitting right at 0x0000 and 0xFFFF, so that every adder and pointer increment gets pushed through the wrap point. The memory responder cycles through zero to two wait cycles, which exercises the request-hold rule and the ignoring of a `start` during an indirect fetch.

// File: rtl/idx_ea_gen.sv
module idx_ea_gen #(
  parameter int AW    = 16,
  parameter int STEPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    base_sel,
  input  logic [STEPW-1:0] step,
  input  logic [4:0]    ofs5,
  input  logic          ofs_sign,
  input  logic [AW/2-1:0] ext_hi,
  input  logic [AW/2-1:0] ext_lo,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_y,
  input  logic [AW-1:0] reg_sp,
  input  logic [AW-1:0] reg_pc,
  input  logic [AW/2-1:0] acc_a,
  input  logic [AW/2-1:0] acc_b,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ready,
  input  logic [AW/2-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_val,
  output logic          illegal
);
  localparam int BW = AW / 2;

  localparam logic [3:0] M_S5 = 4'd0, M_S9 = 4'd1, M_L16 = 4'd2, M_I16 = 4'd3,
                         M_AA = 4'd4, M_AB = 4'd5, M_AD = 4'd6, M_ID  = 4'd7,
                         M_PRI = 4'd8, M_PRD = 4'd9, M_POI = 4'd10, M_POD = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO} st_t;
  st_t st;

  logic [AW-1:0] base, amt, up, dn, nx_ea, nx_wb, ptr_q;
  logic          nx_wben, nx_ill, nx_ind;
  logic [BW-1:0] hi_q;

  always_comb begin
    case (base_sel)
      2'd0:    base = reg_x;
      2'd1:    base = reg_y;
      2'd2:    base = reg_sp;
      default: base = reg_pc;
    endcase
  end

  assign amt = {{(AW-STEPW){1'b0}}, step} + {{(AW-1){1'b0}}, 1'b1};
  assign up  = base + amt;
  assign dn  = base - amt;

  always_comb begin
    nx_ea   = '0;
    nx_wb   = '0;
    nx_wben = 1'b0;
    nx_ill  = 1'b0;
    nx_ind  = 1'b0;
    case (mode)
      M_S5:  nx_ea = base + {{(AW-5){ofs5[4]}}, ofs5};
      M_S9:  nx_ea = base + {{(AW-BW-1){ofs_sign}}, ofs_sign, ext_lo};
      M_L16: nx_ea = base + {ext_hi, ext_lo};
      M_I16: begin nx_ea = base + {ext_hi, ext_lo}; nx_ind = 1'b1; end
      M_AA:  nx_ea = base + {{BW{1'b0}}, acc_a};
      M_AB:  nx_ea = base + {{BW{1'b0}}, acc_b};
      M_AD:  nx_ea = base + {acc_a, acc_b};
      M_ID:  begin nx_ea = base + {acc_a, acc_b}; nx_ind = 1'b1; end
      M_PRI, M_PRD, M_POI, M_POD: begin
        if (base_sel == 2'd3) begin
          nx_ill = 1'b1;
        end else begin
          nx_wben = 1'b1;
          nx_wb   = (mode == M_PRI || mode == M_POI) ? up : dn;
          nx_ea   = (mode == M_PRI || mode == M_PRD) ? nx_wb : base;
        end
      end
      default: nx_ill = 1'b1;
    endcase
  end

  assign rd_valid = (st != S_IDLE);
  assign rd_addr  = ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done    <= 1'b0;
      ea      <= '0;
      wb_en   <= 1'b0;
      wb_val  <= '0;
      illegal <= 1'b0;
      ptr_q   <= '0;
      hi_q    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (nx_ind) begin
            ptr_q <= nx_ea;
            st    <= S_HI;
          end else begin
            done    <= 1'b1;
            ea      <= nx_ea;
            wb_en   <= nx_wben;
            wb_val  <= nx_wb;
            illegal <= nx_ill;
          end
        end
        S_HI: if (rd_ready) begin
          hi_q  <= rd_data;
          ptr_q <= ptr_q + {{(AW-1){1'b0}}, 1'b1};
          st    <= S_LO;
        end
        default: if (rd_ready) begin
          ea      <= {hi_q, rd_data};
          wb_en   <= 1'b0;
          wb_val  <= '0;
          illegal <= 1'b0;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module idx_ea_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [3:0]  mode,
  input logic [1:0]  base_sel,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [15:0] rd_addr,
  input logic        done,
  input logic        wb_en,
  input logic        illegal
);
  a_r1_direct_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_valid && mode != 4'd3 && mode != 4'd7) |=> (done && !rd_valid));

  a_r7_pc_modify: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rd_valid && base_sel == 2'd3 && mode >= 4'd8 && mode <= 4'd11)
      |=> (done && illegal && !wb_en));

  a_r7_illegal_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> !wb_en);

  a_r8_second_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> ((rd_valid && rd_addr == $past(rd_addr) + 16'd1) || (done && !rd_valid)));

  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid);
endmodule

bind idx_ea_gen idx_ea_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_sel(base_sel),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .done(done), .wb_en(wb_en), .illegal(illegal)
);

// File: tb/sim_idx_ea_gen.sv
`timescale 1ns/1ps
module sim_idx_ea_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] base_sel = '0;
  logic [2:0] step = '0;
  logic [4:0] ofs5 = '0;
  logic ofs_sign = 1'b0;
  logic [7:0] ext_hi = '0, ext_lo = '0, acc_a = '0, acc_b = '0;
  logic [15:0] reg_x = '0, reg_y = '0, reg_sp = '0, reg_pc = '0;
  logic rd_valid, rd_ready = 1'b0;
  logic [15:0] rd_addr;
  logic [7:0] rd_data;
  logic done, wb_en, illegal;
  logic [15:0] ea, wb_val;

  int tests = 0, fails = 0, lat = 0, wc = 0, dcount = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  idx_ea_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base_sel(base_sel),
    .step(step), .ofs5(ofs5), .ofs_sign(ofs_sign), .ext_hi(ext_hi), .ext_lo(ext_lo),
    .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp), .reg_pc(reg_pc),
    .acc_a(acc_a), .acc_b(acc_b), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .ea(ea), .wb_en(wb_en),
    .wb_val(wb_val), .illegal(illegal)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    logic [7:0] t;
    t = a[15:8] * 8'd3;
    return t ^ a[7:0] ^ 8'hA5;
  endfunction

  assign rd_data = memf(rd_addr);

  always @(negedge clk) begin
    if (rd_valid) begin
      if (wc >= lat) begin rd_ready = 1'b1; wc = 0; end
      else begin rd_ready = 1'b0; wc = wc + 1; end
    end else begin
      rd_ready = 1'b0; wc = 0;
    end
  end

  always @(posedge clk) if (done) dcount <= dcount + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic string tag(input logic [3:0] m, input logic [1:0] s);
    if (m >= 4'd12 || (m >= 4'd8 && s == 2'd3)) return "R7";
    case (m)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R8";
      4'd7: return "R9";
      4'd8, 4'd9: return "R5";
      4'd10, 4'd11: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic model(output logic [15:0] e, output logic [15:0] w, output logic we, output logic il);
    logic [15:0] b, p, d, amt;
    int o5, o9;
    b = (base_sel == 0) ? reg_x : (base_sel == 1) ? reg_y : (base_sel == 2) ? reg_sp : reg_pc;
    d = {acc_a, acc_b};
    amt = 16'(step) + 16'd1;
    o5 = int'(ofs5) - (ofs5[4] ? 32 : 0);
    o9 = int'(ext_lo) - (ofs_sign ? 256 : 0);
    e = 16'h0; w = 16'h0; we = 1'b0; il = 1'b0;
    case (mode)
      4'd0: e = 16'(int'(b) + o5);
      4'd1: e = 16'(int'(b) + o9);
      4'd2: e = 16'(int'(b) + int'({ext_hi, ext_lo}));
      4'd3: begin p = b + {ext_hi, ext_lo}; e = {memf(p), memf(p + 16'd1)}; end
      4'd4: e = b + 16'(acc_a);
      4'd5: e = b + 16'(acc_b);
      4'd6: e = b + d;
      4'd7: begin p = b + d; e = {memf(p), memf(p + 16'd1)}; end
      4'd8, 4'd9, 4'd10, 4'd11: begin
        if (base_sel == 2'd3) il = 1'b1;
        else begin
          we = 1'b1;
          w = (mode == 4'd8 || mode == 4'd10) ? 16'(int'(b) + int'(amt)) : 16'(int'(b) - int'(amt));
          e = (mode <= 4'd9) ? w : b;
        end
      end
      default: il = 1'b1;
    endcase
  endtask

  task automatic run_op();
    logic [15:0] e, w;
    logic we, il;
    int n;
    string r;
    model(e, w, we, il);
    r = tag(mode, base_sel);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(done, r, 32'(done), 32'd1);
    if (mode != 4'd3 && mode != 4'd7) chk(n == 1, {r, " latency"}, 32'(n), 32'd1);
    chk(ea == e, {r, " ea"}, 32'(ea), 32'(e));
    chk(wb_en == we && illegal == il, {r, " flags"}, {30'd0, wb_en, illegal}, {30'd0, we, il});
    if (we) chk(wb_val == w, {r, " wb_val"}, 32'(wb_val), 32'(w));
    @(negedge clk);
    chk(!done, "R1 pulse", 32'(done), 32'd0);
  endtask

  initial begin
    #1_500_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !rd_valid && !wb_en && !illegal, "R11 flags",
        {28'd0, done, rd_valid, wb_en, illegal}, 32'd0);
    chk(ea == 16'd0 && wb_val == 16'd0, "R11 values", {ea, wb_val}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !rd_valid, "R11 after", {30'd0, done, rd_valid}, 32'd0);

    for (int m = 0; m < 16; m++)
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < 24; i++) begin
          mode = 4'(m); base_sel = 2'(s);
          reg_x = 16'(rnd() >> 8); reg_y = 16'(rnd() >> 8);
          reg_sp = 16'(rnd() >> 8); reg_pc = 16'(rnd() >> 8);
          {acc_a, acc_b} = 16'(rnd() >> 8);
          {ext_hi, ext_lo} = 16'(rnd() >> 8);
          ofs5 = 5'(rnd() >> 11); ofs_sign = 1'(rnd() >> 13);
          step = 3'(i);
          lat = i % 3;
          if (i < 4) begin
            reg_x  = (i[0]) ? 16'hFFFF - 16'(i) : 16'(i);
            reg_y  = reg_x; reg_sp = reg_x; reg_pc = reg_x;
            ofs5 = i[0] ? 5'h0F : 5'h10;
            ofs_sign = ~i[0];
            ext_lo = i[0] ? 8'hFF : 8'h00;
            ext_hi = i[1] ? 8'h7F : 8'h80;
            {acc_a, acc_b} = i[1] ? 16'hFFFF : 16'h00FF;
          end
          run_op();
        end

    // R10: start during an indirect fetch is ignored
    lat = 4;
    mode = 4'd3; base_sel = 2'd1; reg_y = 16'hFFF0; {ext_hi, ext_lo} = 16'h000F;
    begin
      logic [15:0] e, w;
      logic we, il;
      int d0, n;
      model(e, w, we, il);
      d0 = dcount;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b1; mode = 4'd0; ofs5 = 5'd3;
      chk(rd_valid && rd_addr == 16'hFFFF, "R10 request", 32'(rd_addr), 32'hFFFF);
      @(negedge clk); start = 1'b0;
      chk(rd_valid && rd_addr == 16'hFFFF && !done, "R10 hold", 32'(rd_addr), 32'hFFFF);
      n = 0;
      while (!done && n < 40) begin @(negedge clk); n++; end
      chk(ea == e, "R10 ea", 32'(ea), 32'(e));
      chk(ea == {memf(16'hFFFF), memf(16'h0000)}, "R8 wrap", 32'(ea),
          32'({memf(16'hFFFF), memf(16'h0000)}));
      @(negedge clk);
      chk(dcount - d0 == 1, "R10 single done", 32'(dcount - d0), 32'd1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule